// File: doc/BRIEF.md
# Paged Monochrome Display Write Controller

This block takes register writes from a host and builds the image for a 128 by 64 monochrome panel in a local frame memory. The memory is organised as eight horizontal bands ("pages") of 128 bytes. Each byte holds a vertical strip of eight pixels in one column of one band. A 32-bit mode register decides what a write to the data register means. In command mode the write can move the write cursor to another band. In pixel mode the byte is stored at the cursor, and the cursor then steps to the next column. A separate instruction register can move the cursor at any time.

A scan-out engine reads the image one pixel at a time through an address port. One cycle later it gets the pixel bit and a 24-bit colour. That colour is a fixed ink colour scaled by a 3-bit brightness input, or black for a dark pixel.

Top module: `lcd_page_ctrl`

## Requirements
- R1: After reset the cursor is at band 0, column 0, and the mode is invalid, so data-register writes are dropped until a valid mode is written.
- R2: A write to the mode register (select code 0) sets pixel mode only for the exact value 0x00100011 and command mode only for 0x00104011. Any other value makes the mode invalid.
- R3: In command mode, a data-register write (select code 2) of a full 32-bit value from 0xB0 to 0xB7 moves the cursor to band (value − 0xB0) and column 0. Any other value leaves the cursor unchanged and stores nothing.
- R4: In pixel mode, a data-register write stores bits [7:0] at byte address band·128 + column, and the column then advances by one. After column 127 the column wraps to 0 within the same band.
- R5: A write to the instruction register (select code 1) of a value from 0xB0 to 0xB7 moves the cursor to that band and column 0 in any mode, including invalid. Other values are ignored.
- R6: The pixel at column x (rd_col) and row y (rd_row) is bit (y mod 8) of byte x + (y div 8)·128. It appears on rd_pixel one clock after the address.
- R7: With rd_pixel set, each byte of rd_rgb equals floor(c·b/7). Here c is 0xE0, 0xE0 and 0xFF for bits [23:16], [15:8] and [7:0], and b is bright_in sampled with the address. A dark pixel gives 0. Brightness 0 gives black and 7 gives 0xE0E0FF.
- R8: While the mode is invalid, data-register writes change neither the frame memory nor the cursor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 instruction, 2 data, 3 unused |
| wr_data | input | 32 | Write value |
| rd_col | input | 7 | Scan-out column |
| rd_row | input | 6 | Scan-out row |
| bright_in | input | 3 | Brightness level 0 to 7 |
| rd_pixel | output | 1 | Pixel bit, one cycle after the address |
| rd_rgb | output | 24 | Scaled colour of the pixel, RRGGBB |

## Verification
Some rules are checked by assertions on every cycle. An invalid mode freezes the cursor, and any mode value other than the two exact ones makes the mode invalid. A band selection sets the column to zero, and the column wraps after 127. A dark pixel yields black, and full brightness yields the ink colour. Other behaviour shows only in the bench's scenarios, which read the memory back through the scan-out port. These cover where bytes actually land, the band and column left after reset, and that dropped writes do not corrupt stored bytes. They also cover that the column is kept across a detour through invalid mode, and the intermediate brightness values.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef enum logic [1:0] {
    MODE_INVALID = 2'd0,
    MODE_PIXEL   = 2'd1,
    MODE_CMD     = 2'd2
  } lcd_mode_e;

  localparam logic [1:0]  SEL_MODE  = 2'd0;
  localparam logic [1:0]  SEL_INSTR = 2'd1;
  localparam logic [1:0]  SEL_DATA  = 2'd2;

  localparam logic [31:0] MAGIC_PIXEL = 32'h0010_0011;
  localparam logic [31:0] MAGIC_CMD   = 32'h0010_4011;
  localparam logic [31:0] BAND_CMD_BASE = 32'h0000_00B0;
endpackage

// File: rtl/lcd_mode_reg.sv
module lcd_mode_reg
  import lcd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_wr,
  input  logic [31:0] mode_val,
  output lcd_mode_e   mode_o
);
  lcd_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (mode_wr) begin
      if (mode_val == MAGIC_PIXEL)    mode_d = MODE_PIXEL;
      else if (mode_val == MAGIC_CMD) mode_d = MODE_CMD;
      else                            mode_d = MODE_INVALID;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_INVALID;
    else if (mode_wr) mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R2: a non-magic value always lands in invalid mode
  a_r2_bad_value_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_val != MAGIC_PIXEL && mode_val != MAGIC_CMD) |=> (mode_o == MODE_INVALID));
  // R2: exact command value selects command mode
  a_r2_cmd_value: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_val == MAGIC_CMD) |=> (mode_o == MODE_CMD));
endmodule

// File: rtl/lcd_cursor.sv
module lcd_cursor #(
  parameter int COLS  = 128,
  parameter int BANDS = 8,
  localparam int COL_W  = $clog2(COLS),
  localparam int BAND_W = $clog2(BANDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              band_load,
  input  logic [BAND_W-1:0] band_val,
  input  logic              col_step,
  output logic [BAND_W-1:0] band_o,
  output logic [COL_W-1:0]  col_o
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

  logic [BAND_W-1:0] band_q, band_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic              cur_en;

  assign cur_en = band_load | col_step;

  always_comb begin
    band_d = band_q;
    col_d  = col_q;
    if (band_load) begin
      band_d = band_val;
      col_d  = '0;
    end else if (col_step) begin
      col_d = (col_q == COL_LAST) ? '0 : col_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      band_q <= '0;
      col_q  <= '0;
    end else if (cur_en) begin
      band_q <= band_d;
      col_q  <= col_d;
    end
  end

  assign band_o = band_q;
  assign col_o  = col_q;

  // R3/R5: any band selection restarts at column zero
  a_r3_band_load_col_zero: assert property (@(posedge clk) disable iff (!rst_n)
    band_load |=> (col_o == '0 && band_o == $past(band_val)));
  // R4: stepping from the last column wraps inside the band
  a_r4_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (col_step && !band_load && col_o == COL_LAST) |=> (col_o == '0 && $stable(band_o)));
endmodule

// File: rtl/lcd_frame_mem.sv
module lcd_frame_mem #(
  parameter int COLS  = 128,
  parameter int BANDS = 8,
  localparam int DEPTH = COLS * BANDS,
  localparam int ADR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ADR_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [ADR_W-1:0] raddr,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lcd_shade.sv
module lcd_shade #(
  parameter logic [23:0] INK     = 24'hE0E0FF,
  parameter int          LEVEL_W = 3,
  localparam int         PROD_W  = 8 + LEVEL_W,
  localparam int         LEVEL_MAX = (1 << LEVEL_W) - 1
) (
  input  logic [LEVEL_W-1:0] level,
  input  logic               lit,
  output logic [23:0]        rgb
);
  for (genvar g = 0; g < 3; g++) begin : g_comp
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;
    assign prod   = PROD_W'(INK[8*g +: 8]) * PROD_W'(level);
    assign scaled = prod / PROD_W'(LEVEL_MAX);
    assign rgb[8*g +: 8] = lit ? scaled[7:0] : 8'h00;
  end
endmodule

// File: rtl/lcd_page_ctrl.sv
module lcd_page_ctrl
  import lcd_pkg::*;
#(
  parameter int          COLS    = 128,
  parameter int          BANDS   = 8,
  parameter int          LEVEL_W = 3,
  parameter logic [23:0] INK     = 24'hE0E0FF,
  localparam int COL_W  = $clog2(COLS),
  localparam int BAND_W = $clog2(BANDS),
  localparam int ROW_W  = BAND_W + 3,
  localparam int ADR_W  = BAND_W + COL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [31:0]        wr_data,
  input  logic [COL_W-1:0]   rd_col,
  input  logic [ROW_W-1:0]   rd_row,
  input  logic [LEVEL_W-1:0] bright_in,
  output logic               rd_pixel,
  output logic [23:0]        rd_rgb
);
  localparam logic [31:0] BAND_CMD_LAST = BAND_CMD_BASE + 32'(BANDS - 1);

  lcd_mode_e         mode;
  logic              band_cmd_ok;
  logic              instr_hit, data_cmd_hit, store, mode_wr, band_load;
  logic [BAND_W-1:0] band_val, band;
  logic [COL_W-1:0]  col;
  logic [31:0]       band_off;
  logic [7:0]        rbyte;
  logic [2:0]        bit_q;
  logic [LEVEL_W-1:0] level_q;

  // write decode
  assign band_cmd_ok  = (wr_data >= BAND_CMD_BASE) && (wr_data <= BAND_CMD_LAST);
  assign band_off     = wr_data - BAND_CMD_BASE;
  assign band_val     = band_off[BAND_W-1:0];
  assign mode_wr      = wr_en && (wr_sel == SEL_MODE);
  assign instr_hit    = wr_en && (wr_sel == SEL_INSTR) && band_cmd_ok;
  assign data_cmd_hit = wr_en && (wr_sel == SEL_DATA) && (mode == MODE_CMD) && band_cmd_ok;
  assign store        = wr_en && (wr_sel == SEL_DATA) && (mode == MODE_PIXEL);
  assign band_load    = instr_hit | data_cmd_hit;

  lcd_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_wr  (mode_wr),
    .mode_val (wr_data),
    .mode_o   (mode)
  );

  lcd_cursor #(.COLS(COLS), .BANDS(BANDS)) u_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .band_load (band_load),
    .band_val  (band_val),
    .col_step  (store),
    .band_o    (band),
    .col_o     (col)
  );

  lcd_frame_mem #(.COLS(COLS), .BANDS(BANDS)) u_mem (
    .clk   (clk),
    .we    (store),
    .waddr ({band, col}),
    .wdata (wr_data[7:0]),
    .raddr ({rd_row[ROW_W-1:3], rd_col}),
    .rdata (rbyte)
  );

  // read side: bit index and brightness travel with the memory read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= '0;
      level_q <= '0;
    end else begin
      bit_q   <= rd_row[2:0];
      level_q <= bright_in;
    end
  end

  assign rd_pixel = rbyte[bit_q];

  lcd_shade #(.INK(INK), .LEVEL_W(LEVEL_W)) u_shade (
    .level (level_q),
    .lit   (rd_pixel),
    .rgb   (rd_rgb)
  );

  // R8: data writes in invalid mode leave the cursor alone
  a_r8_invalid_holds_cursor: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_DATA && mode == MODE_INVALID && !instr_hit)
      |=> ($stable(band) && $stable(col)));
  // R4: a stored byte moves the cursor off its column
  a_r4_store_moves_col: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> (col != $past(col)));
  // R7: dark pixels are black
  a_r7_dark_black: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_pixel |-> (rd_rgb == 24'h0));
  // R7: top brightness gives the ink colour unchanged
  a_r7_full_ink: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bright_in) == LEVEL_W'((1 << LEVEL_W) - 1) && rd_pixel) |-> (rd_rgb == INK));
endmodule

// File: tb/lcd_page_ctrl_tb_top.sv
`timescale 1ns/1ps
module lcd_page_ctrl_tb_top;
  logic        clk, rst_n, wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [6:0]  rd_col;
  logic [5:0]  rd_row;
  logic [2:0]  bright_in;
  logic        rd_pixel;
  logic [23:0] rd_rgb;

  int checks = 0, failures = 0;
  bit done = 0;

  lcd_page_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_col(rd_col), .rd_row(rd_row), .bright_in(bright_in),
    .rd_pixel(rd_pixel), .rd_rgb(rd_rgb)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] val);
    wr_en = 1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_byte(input int band, input int col, output logic [7:0] v);
    for (int b = 0; b < 8; b++) begin
      rd_col = 7'(col); rd_row = 6'(band * 8 + b);
      @(negedge clk);
      v[b] = rd_pixel;
    end
  endtask

  task automatic expect_byte(input int band, input int col, input logic [7:0] exp, input string req);
    logic [7:0] v;
    rd_byte(band, col, v);
    check(v === exp, req, 32'(v), 32'(exp));
  endtask

  localparam logic [31:0] PIX = 32'h0010_0011, CMD = 32'h0010_4011;

  task automatic t_data_fill();  // R4 R5
    wr(2'd0, PIX);
    wr(2'd1, 32'hB2);
    wr(2'd2, 32'h11); wr(2'd2, 32'h22); wr(2'd2, 32'hF33);
    expect_byte(2, 0, 8'h11, "R4 byte0");
    expect_byte(2, 1, 8'h22, "R4 byte1");
    expect_byte(2, 2, 8'h33, "R4 low byte only");
  endtask

  task automatic t_reset_state();  // R1 R8
    do_reset();
    wr(2'd2, 32'hAA);
    expect_byte(2, 0, 8'h11, "R1 invalid after reset");
    wr(2'd0, PIX);
    wr(2'd2, 32'h5A);
    expect_byte(0, 0, 8'h5A, "R1 cursor at band0 col0");
    expect_byte(2, 0, 8'h11, "R1 other band untouched");
  endtask

  task automatic t_modes();  // R2 R3 R8
    wr(2'd0, CMD);
    wr(2'd2, 32'hB5);
    wr(2'd0, PIX);
    wr(2'd2, 32'h77); wr(2'd2, 32'h66);
    wr(2'd0, 32'h0010_0012);
    wr(2'd2, 32'h99);
    wr(2'd0, PIX);
    wr(2'd2, 32'h44);
    expect_byte(5, 0, 8'h77, "R3 data cmd band select");
    expect_byte(5, 1, 8'h66, "R8 invalid write dropped");
    expect_byte(5, 2, 8'h44, "R2 near-magic invalid, column kept");
  endtask

  task automatic t_cmd_ignore();  // R3
    wr(2'd0, CMD);
    wr(2'd2, 32'hB8); wr(2'd2, 32'h1B0); wr(2'd2, 32'h1F);
    wr(2'd0, PIX);
    wr(2'd2, 32'h21);
    expect_byte(5, 3, 8'h21, "R3 out-of-range cmd ignored");
  endtask

  task automatic t_wrap();  // R4
    wr(2'd1, 32'hB7);
    for (int i = 0; i < 128; i++) wr(2'd2, 32'(i ^ 8'h5C));
    wr(2'd2, 32'hEE);
    expect_byte(7, 0, 8'hEE, "R4 wrap to col0");
    expect_byte(7, 1, 8'(1 ^ 8'h5C), "R4 col1 kept");
    expect_byte(7, 127, 8'(127 ^ 8'h5C), "R4 col127");
  endtask

  task automatic t_instr();  // R5
    wr(2'd0, 32'h0);
    wr(2'd1, 32'hB1);
    wr(2'd1, 32'hC0);
    wr(2'd0, PIX);
    wr(2'd2, 32'h3C);
    expect_byte(1, 0, 8'h3C, "R5 instr in invalid mode");
    wr(2'd0, CMD);
    wr(2'd1, 32'hB6);
    wr(2'd0, PIX);
    wr(2'd2, 32'h81);
    expect_byte(6, 0, 8'h81, "R5 instr in cmd mode");
  endtask

  task automatic t_pixel_colour();  // R6 R7
    int lv [4] = '{7, 3, 1, 0};
    rd_col = 0; rd_row = 6'd10; bright_in = 3'd7;  // band1 col0 = 0x3C, bit2 = 1
    @(negedge clk);
    check(rd_pixel === 1'b1, "R6 lit pixel", 32'(rd_pixel), 32'd1);
    rd_row = 6'd8;
    @(negedge clk);
    check(rd_pixel === 1'b0, "R6 dark pixel", 32'(rd_pixel), 32'd0);
    check(rd_rgb === 24'h0, "R7 dark black", 32'(rd_rgb), 32'h0);
    foreach (lv[k]) begin
      logic [23:0] e;
      e = {8'((224 * lv[k]) / 7), 8'((224 * lv[k]) / 7), 8'((255 * lv[k]) / 7)};
      rd_row = 6'd10; bright_in = 3'(lv[k]);
      @(negedge clk);
      check(rd_rgb === e, "R7 scaled colour", 32'(rd_rgb), 32'(e));
    end
  endtask

  initial begin
    rd_col = 0; rd_row = 0; bright_in = 0;
    do_reset();
    t_data_fill();
    t_reset_state();
    t_modes();
    t_cmd_ignore();
    t_wrap();
    t_instr();
    t_pixel_colour();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule